// File: doc/BRIEF.md
# Legacy Memory Attribute Decoder

This block sits in a host bridge and decides, for each host memory access below 1 MiB, whether DRAM serves it or whether it is passed on to the expansion bus. Everything below 0xA0000 is plain DRAM. The 128 KiB video window at 0xA0000–0xBFFFF follows a system-management RAM control byte combined with the live SMM-active input. The expansion-ROM area at 0xC0000–0xEFFFF is split into twelve 16 KiB segments. The BIOS segment at 0xF0000–0xFFFFF is one 64 KiB segment. Each of these thirteen segments takes a 2-bit attribute from a set of configuration bytes.

Software programs the block through a byte-wide configuration port. It has a write strobe, a write offset and write data, plus a separate combinational read offset and read data. A read-only byte reports the installed DRAM size in 8 MiB units. Decoding is purely combinational from the access address, the write flag, the SMM input and the current register contents. A configuration write therefore steers accesses from the cycle after the write edge.

Top module: `lmem_attr_dec`

## Requirements
- R1: After reset, offsets 0x59–0x5F read 0x00 and offset 0x72 reads 0x02. In this state every access in 0xA0000–0xFFFFF is forwarded to the bus.
- R2: Any access below 0xA0000, read or write, selects DRAM and is not forwarded.
- R3: Any access at or above 0x100000 drives neither output.
- R4: Segment 0xF0000–0xFFFFF uses bits [5:4] of offset 0x59 as its attribute. The other bits of that byte have no effect on decoding.
- R5: The segment at 0xC0000 + i·0x4000 (i = 0..11) uses offset 0x5A + i/2. It takes bits [1:0] for even i and bits [5:4] for odd i.
- R6: Attribute 3 selects DRAM for reads and writes. Attribute 1 selects DRAM for reads, and a write drives neither output (the write is discarded). Attributes 0 and 2 forward to the bus.
- R7: The window 0xA0000–0xBFFFF selects DRAM when bit 6 of offset 0x72 is 1, or when bit 3 is 1 while smm_i is 1. Otherwise it forwards to the bus.
- R8: A change on smm_i changes the window decode in the same cycle, with no register stage.
- R9: Offset 0x57 reads min(DRAM_MIB/8, 255). A write to it is ignored.
- R10: A write to 0x59–0x5F or 0x72 is read back and steers decoding from the next cycle. Other offsets read 0x00 and ignore writes.
- R11: dram_sel_o and bus_fwd_o are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_waddr_i | input | 8 | Configuration write offset |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_raddr_i | input | 8 | Configuration read offset |
| cfg_rdata_o | output | 8 | Configuration read data (combinational) |
| smm_i | input | 1 | System-management mode active |
| acc_addr_i | input | 32 | Host access address |
| acc_we_i | input | 1 | Access is a write |
| dram_sel_o | output | 1 | Access goes to DRAM |
| bus_fwd_o | output | 1 | Access is forwarded to the expansion bus |

## Verification
The bench aims at the nibble selection of the twelve ROM segments. It sets different attributes in the low and high halves of one byte and probes both ends of each segment. A design that mixed up the halves or the byte index would route the neighbouring segment's way. Writes to read-only segments must drive neither output; a design treating attribute 1 as full DRAM would assert dram_sel_o on a write. The window is probed with only the SMM-gated enable set while smm_i toggles, which catches a design that ignores smm_i or registers it. Addresses one below and one at 0xA0000, 0xC0000, 0xF0000 and 0x100000 catch off-by-one region compares. A write to the read-only size byte must leave the read value unchanged.

// File: rtl/lmem_pkg.sv
package lmem_pkg;
  typedef enum logic [1:0] {
    ATTR_BUS_A = 2'd0,
    ATTR_RO    = 2'd1,
    ATTR_BUS_B = 2'd2,
    ATTR_RW    = 2'd3
  } attr_e;

  localparam logic [7:0] OFF_SIZE   = 8'h57;
  localparam logic [7:0] OFF_ATTR0  = 8'h59;
  localparam logic [7:0] OFF_SMRAM  = 8'h72;
  localparam int         NUM_AREGS  = 7;
  localparam int         NUM_SEG    = 12;
  localparam logic [7:0] SMRAM_RST  = 8'h02;
  localparam int         SM_OPEN_B  = 6;
  localparam int         SM_EN_B    = 3;

  localparam logic [31:0] WIN_BASE  = 32'h000A_0000;
  localparam logic [31:0] ROM_BASE  = 32'h000C_0000;
  localparam logic [31:0] BIOS_BASE = 32'h000F_0000;
  localparam logic [31:0] DEC_LIMIT = 32'h0010_0000;
endpackage

// File: rtl/lmem_cfg_regs.sv
module lmem_cfg_regs
  import lmem_pkg::*;
#(
  parameter int DRAM_MIB = 128
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [7:0]                  waddr_i,
  input  logic [7:0]                  wdata_i,
  input  logic [7:0]                  raddr_i,
  output logic [7:0]                  rdata_o,
  output logic [1:0]                  top_attr_o,
  output logic [NUM_SEG-1:0][1:0]     seg_attr_o,
  output logic                        sm_open_o,
  output logic                        sm_en_o
);
  localparam int         SIZE_UNITS = (DRAM_MIB / 8 > 255) ? 255 : DRAM_MIB / 8;
  localparam logic [7:0] SIZE_VAL   = 8'(SIZE_UNITS);

  logic [NUM_AREGS-1:0][7:0] attr_q;
  logic [7:0]                smram_q;

  for (genvar g = 0; g < NUM_AREGS; g++) begin : g_areg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   attr_q[g] <= 8'h00;
      else if (we_i && waddr_i == OFF_ATTR0 + 8'(g)) attr_q[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           smram_q <= SMRAM_RST;
    else if (we_i && waddr_i == OFF_SMRAM) smram_q <= wdata_i;
  end

  always_comb begin
    rdata_o = 8'h00;
    if (raddr_i == OFF_SIZE)  rdata_o = SIZE_VAL;
    if (raddr_i == OFF_SMRAM) rdata_o = smram_q;
    for (int i = 0; i < NUM_AREGS; i++)
      if (raddr_i == OFF_ATTR0 + 8'(i)) rdata_o = attr_q[i];
  end

  // top segment lives in the high nibble of the first byte
  assign top_attr_o = attr_q[0][5:4];
  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    assign seg_attr_o[s] = attr_q[1 + s/2][(s%2)*4 +: 2];
  end

  assign sm_open_o = smram_q[SM_OPEN_B];
  assign sm_en_o   = smram_q[SM_EN_B];

  AST_SMRAM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && waddr_i == OFF_SMRAM |=> smram_q == $past(wdata_i)); // R10
  AST_ATTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(attr_q)); // R10
endmodule

// File: rtl/lmem_route.sv
module lmem_route
  import lmem_pkg::*;
(
  input  logic [31:0]             addr_i,
  input  logic                    we_i,
  input  logic                    smm_i,
  input  logic [1:0]              top_attr_i,
  input  logic [NUM_SEG-1:0][1:0] seg_attr_i,
  input  logic                    sm_open_i,
  input  logic                    sm_en_i,
  output logic                    dram_o,
  output logic                    bus_o
);
  logic [3:0] seg_idx;
  attr_e      attr;

  assign seg_idx = addr_i[17:14];

  always_comb begin
    attr = ATTR_BUS_A;
    if (addr_i >= BIOS_BASE) attr = attr_e'(top_attr_i);
    else if (seg_idx < 4'(NUM_SEG)) attr = attr_e'(seg_attr_i[seg_idx]);
  end

  always_comb begin
    dram_o = 1'b0;
    bus_o  = 1'b0;
    if (addr_i < WIN_BASE) begin
      dram_o = 1'b1;
    end else if (addr_i < ROM_BASE) begin
      if (sm_open_i || (sm_en_i && smm_i)) dram_o = 1'b1;
      else                                 bus_o  = 1'b1;
    end else if (addr_i < DEC_LIMIT) begin
      unique case (attr)
        ATTR_RW: dram_o = 1'b1;
        ATTR_RO: dram_o = !we_i;  // writes dropped
        default: bus_o  = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/lmem_attr_dec.sv
module lmem_attr_dec
  import lmem_pkg::*;
#(
  parameter int DRAM_MIB = 128
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic [7:0]  cfg_waddr_i,
  input  logic [7:0]  cfg_wdata_i,
  input  logic [7:0]  cfg_raddr_i,
  output logic [7:0]  cfg_rdata_o,
  input  logic        smm_i,
  input  logic [31:0] acc_addr_i,
  input  logic        acc_we_i,
  output logic        dram_sel_o,
  output logic        bus_fwd_o
);
  logic [1:0]              top_attr;
  logic [NUM_SEG-1:0][1:0] seg_attr;
  logic                    sm_open, sm_en;

  lmem_cfg_regs #(.DRAM_MIB(DRAM_MIB)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .waddr_i    (cfg_waddr_i),
    .wdata_i    (cfg_wdata_i),
    .raddr_i    (cfg_raddr_i),
    .rdata_o    (cfg_rdata_o),
    .top_attr_o (top_attr),
    .seg_attr_o (seg_attr),
    .sm_open_o  (sm_open),
    .sm_en_o    (sm_en)
  );

  lmem_route u_route (
    .addr_i     (acc_addr_i),
    .we_i       (acc_we_i),
    .smm_i      (smm_i),
    .top_attr_i (top_attr),
    .seg_attr_i (seg_attr),
    .sm_open_i  (sm_open),
    .sm_en_i    (sm_en),
    .dram_o     (dram_sel_o),
    .bus_o      (bus_fwd_o)
  );

  AST_LOW_DRAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_addr_i < WIN_BASE |-> dram_sel_o && !bus_fwd_o); // R2
  AST_HIGH_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_addr_i >= DEC_LIMIT |-> !dram_sel_o && !bus_fwd_o); // R3
  AST_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dram_sel_o && bus_fwd_o)); // R11
  AST_WIN_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_addr_i >= WIN_BASE && acc_addr_i < ROM_BASE && sm_open |-> dram_sel_o); // R7
  AST_WIN_SMM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_addr_i >= WIN_BASE && acc_addr_i < ROM_BASE && !sm_open && sm_en
    |-> dram_sel_o == smm_i); // R8
  AST_RO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_addr_i >= BIOS_BASE && acc_addr_i < DEC_LIMIT && top_attr == 2'd1 && acc_we_i
    |-> !dram_sel_o && !bus_fwd_o); // R6
endmodule

// File: tb/lmem_attr_dec_test.sv
module lmem_attr_dec_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_waddr = 8'h00, cfg_wdata = 8'h00, cfg_raddr = 8'h00;
  logic [7:0]  cfg_rdata;
  logic        smm = 1'b0;
  logic [31:0] acc_addr = 32'h0;
  logic        acc_we = 1'b0;
  logic        dram_sel, bus_fwd;

  int checks = 0;
  int failures = 0;

  logic [7:0] m_attr [7];
  logic [7:0] m_smram;
  localparam logic [7:0] SIZE_EXP = 8'd16;

  always #5 clk = ~clk;

  lmem_attr_dec #(.DRAM_MIB(128)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_we_i(cfg_we), .cfg_waddr_i(cfg_waddr), .cfg_wdata_i(cfg_wdata),
    .cfg_raddr_i(cfg_raddr), .cfg_rdata_o(cfg_rdata),
    .smm_i(smm), .acc_addr_i(acc_addr), .acc_we_i(acc_we),
    .dram_sel_o(dram_sel), .bus_fwd_o(bus_fwd)
  );

  // returns {dram, bus}
  function automatic logic [1:0] exp_route(logic [31:0] a, logic w, logic s);
    logic [1:0] at;
    int i;
    if (a < 32'hA0000) return 2'b10;
    if (a >= 32'h100000) return 2'b00;
    if (a < 32'hC0000) return (m_smram[6] || (m_smram[3] && s)) ? 2'b10 : 2'b01;
    if (a >= 32'hF0000) at = m_attr[0][5:4];
    else begin
      i = int'((a - 32'hC0000) >> 14);
      at = (i % 2 == 0) ? m_attr[1 + i/2][1:0] : m_attr[1 + i/2][5:4];
    end
    case (at)
      2'd3: return 2'b10;
      2'd1: return w ? 2'b00 : 2'b10;
      default: return 2'b01;
    endcase
  endfunction

  function automatic logic [7:0] exp_read(logic [7:0] off);
    if (off == 8'h57) return SIZE_EXP;
    if (off == 8'h72) return m_smram;
    if (off >= 8'h59 && off <= 8'h5F) return m_attr[off - 8'h59];
    return 8'h00;
  endfunction

  task automatic cfg_wr(input logic [7:0] off, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_waddr = off; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (off == 8'h72) m_smram = d;
    if (off >= 8'h59 && off <= 8'h5F) m_attr[off - 8'h59] = d;
  endtask

  task automatic chk_acc(input logic [31:0] a, input logic w, input logic s, input string req);
    logic [1:0] e;
    @(negedge clk);
    acc_addr = a; acc_we = w; smm = s;
    #1;
    e = exp_route(a, w, s);
    checks++;
    if ({dram_sel, bus_fwd} !== e) begin
      failures++;
      $display("FAIL %s addr=%h we=%0b smm=%0b got dram/bus=%b exp=%b", req, a, w, s, {dram_sel, bus_fwd}, e);
    end
  endtask

  task automatic chk_rd(input logic [7:0] off, input string req);
    logic [7:0] e;
    @(negedge clk);
    cfg_raddr = off;
    #1;
    e = exp_read(off);
    checks++;
    if (cfg_rdata !== e) begin
      failures++;
      $display("FAIL %s off=%h got=%h exp=%h", req, off, cfg_rdata, e);
    end
  endtask

  initial begin
    #5ms;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] a;
    logic [7:0]  off;
    for (int i = 0; i < 7; i++) m_attr[i] = 8'h00;
    m_smram = 8'h02;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    for (int o = 8'h59; o <= 8'h5F; o++) chk_rd(8'(o), "R1");
    chk_rd(8'h72, "R1");
    chk_acc(32'hA0000, 1'b0, 1'b0, "R1");
    chk_acc(32'hC0000, 1'b0, 1'b0, "R1");
    chk_acc(32'hF0000, 1'b1, 1'b0, "R1");
    chk_acc(32'hFFFFF, 1'b0, 1'b1, "R1");

    // R9 size byte, write ignored
    chk_rd(8'h57, "R9");
    cfg_wr(8'h57, 8'hAA);
    chk_rd(8'h57, "R9");

    // R2 / R3 boundaries
    chk_acc(32'h00000, 1'b1, 1'b0, "R2");
    chk_acc(32'h9FFFF, 1'b0, 1'b1, "R2");
    chk_acc(32'h100000, 1'b0, 1'b0, "R3");
    chk_acc(32'hFFFFFFFF, 1'b1, 1'b1, "R3");

    // R4 top segment
    cfg_wr(8'h59, 8'h30);
    chk_acc(32'hF0000, 1'b1, 1'b0, "R4");
    chk_acc(32'hEFFFF, 1'b0, 1'b0, "R4");
    cfg_wr(8'h59, 8'h10);
    chk_acc(32'hFFFFF, 1'b1, 1'b0, "R4_R6");
    chk_acc(32'hFFFFF, 1'b0, 1'b0, "R4_R6");
    cfg_wr(8'h59, 8'hCF);
    chk_acc(32'hF8000, 1'b0, 1'b0, "R4");

    // R5 / R6 segment nibbles
    cfg_wr(8'h5A, 8'h31);
    chk_acc(32'hC0000, 1'b0, 1'b0, "R5");
    chk_acc(32'hC3FFF, 1'b1, 1'b0, "R5_R6");
    chk_acc(32'hC4000, 1'b1, 1'b0, "R5");
    chk_acc(32'hC8000, 1'b0, 1'b0, "R5");
    cfg_wr(8'h5F, 8'h13);
    chk_acc(32'hE8000, 1'b1, 1'b0, "R5");
    chk_acc(32'hEC000, 1'b1, 1'b0, "R5_R6");
    chk_acc(32'hEFFFF, 1'b0, 1'b0, "R5");
    cfg_wr(8'h5C, 8'h20);
    chk_acc(32'hD0000, 1'b0, 1'b0, "R6");
    chk_acc(32'hD4000, 1'b1, 1'b0, "R6");

    // R7 / R8 window
    cfg_wr(8'h72, 8'h40);
    chk_acc(32'hA0000, 1'b1, 1'b0, "R7");
    chk_acc(32'hBFFFF, 1'b0, 1'b0, "R7");
    cfg_wr(8'h72, 8'h08);
    chk_acc(32'hB0000, 1'b0, 1'b0, "R7_R8");
    chk_acc(32'hB0000, 1'b0, 1'b1, "R8");
    chk_acc(32'hB0000, 1'b1, 1'b0, "R8");
    chk_acc(32'hC0000, 1'b0, 1'b1, "R7");

    // R10 read-back and unmapped offsets
    chk_rd(8'h72, "R10");
    chk_rd(8'h5A, "R10");
    cfg_wr(8'h60, 8'h77);
    chk_rd(8'h60, "R10");
    chk_rd(8'h58, "R10");

    // random mix, R11 exclusivity checked by every compare
    for (int it = 0; it < 3000; it++) begin
      if (it % 6 == 0) begin
        case ($urandom % 4)
          0: off = 8'h59 + 8'($urandom % 7);
          1: off = 8'h72;
          2: off = 8'h57;
          default: off = 8'($urandom);
        endcase
        cfg_wr(off, 8'($urandom));
      end
      case ($urandom % 4)
        0: a = $urandom;
        1: a = 32'hA0000 + ($urandom % 32'h60000);
        2: a = $urandom % 32'h100000;
        default: begin
          case ($urandom % 5)
            0: a = 32'h9FFFF; 1: a = 32'hBFFFF; 2: a = 32'hC0000;
            3: a = 32'hF0000; default: a = 32'h100000;
          endcase
        end
      endcase
      chk_acc(a, 1'($urandom), 1'($urandom), "R11_RND");
      if (it % 50 == 0) chk_rd(8'h59 + 8'($urandom % 7), "R10_RND");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule